// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block sends one stereo pair of 24-bit two's-complement samples per frame on a single serial data line. It shares one bit clock and one frame clock between both channels. Every frame holds 64 bit-clock slots, 32 for each channel. A 3-bit format code picks one of four framings: I2S, left-justified, right-justified, or a DSP style with a one-slot frame pulse. A 2-bit width code picks 16, 20 or 24 significant bits per word. The most significant bits of each sample go out first, and every slot that carries no sample bit is driven low.

A mode strap sets the clocking. In master mode the block divides its system clock down to a bit clock and drives both clocks itself. In slave mode it takes bit and frame clocks from outside, synchronises them to the system clock, and re-aligns its slot counter whenever it sees the frame-start edge. Output data always changes after the falling edge of the bit clock, so a receiver samples on the rising edge. Both channel words are captured at the start of each frame.

Top module: `aud_serial_tx`

## Requirements
- R1: While reset is high, and after it is released until the first bit-clock falling edge, `sdata_out`, `bclk_out` and `fclk_out` are all 0.
- R2: In master mode `bclk_out` has a period of 2*HALF_DIV system clocks and a frame lasts 64 bit clocks. `sdata_out` and `fclk_out` change only together with a falling edge of `bclk_out`.
- R3: Format code 0, and also codes 4 to 7, selects I2S. `fclk` is low for slots 0 to 31 (left) and high for slots 32 to 63 (right), and each word's MSB sits in the slot after the frame-clock edge (slots 1 and 33).
- R4: Format code 3 selects left-justified. `fclk` is high for slots 0 to 31 (left) and low for slots 32 to 63, and each MSB sits in the slot of the frame-clock edge (slots 0 and 32).
- R5: Format code 1 selects right-justified. Its frame clock is the same as in R4, and each word ends with its LSB in the last slot of its half (slots 31 and 63), starting at slot 32-W or 64-W.
- R6: Format code 2 selects DSP framing. `fclk` is high only in slot 0, the left MSB is in slot 1, and the right word follows at once, from slot 1+W to slot 2W.
- R7: Width code 0 gives W=16, code 1 gives W=20, and codes 2 and 3 give W=24. Each channel sends sample bits 23 down to 24-W, MSB first.
- R8: Every slot that carries no sample bit drives `sdata_out` low.
- R9: In slave mode `bclk_out` and `fclk_out` stay 0, and data follows `bclk_in` and `fclk_in` with the framing of R3 to R8. From the second full frame after a frame-start edge, the output is aligned.
- R10: `left_in` and `right_in` are captured when the frame moves into slot 0. A change to them later in the frame only shows in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_mode | input | 1 | Mode strap: 1 = block drives the clocks, 0 = clocks come from outside |
| fmt_sel | input | 3 | Framing code (0 I2S, 1 right-justified, 2 DSP, 3 left-justified, 4-7 I2S) |
| width_sel | input | 2 | Word length code (0 = 16, 1 = 20, 2 and 3 = 24 bits) |
| left_in | input | SAMPLE_W | Left-channel sample, two's complement |
| right_in | input | SAMPLE_W | Right-channel sample, two's complement |
| bclk_in | input | 1 | External bit clock (slave mode) |
| fclk_in | input | 1 | External frame clock (slave mode) |
| bclk_out | output | 1 | Generated bit clock (master mode, else 0) |
| fclk_out | output | 1 | Generated frame clock (master mode, else 0) |
| sdata_out | output | 1 | Serial data, changes after bit-clock falling edges |

## Verification
The assertions assume that the mode strap and the format code do not change between two resets. If the format changed in the middle of a frame, the frame clock could switch level in a slot that carries data. The bench therefore pulses reset before each new format and mode. In slave mode the checks assume that each external bit-clock phase lasts many system clocks and that the external frame clock changes only while the bit clock is low. The bench holds each phase for 8 system clocks and moves the frame clock only at falling bit-clock edges.

// File: rtl/aud_serial_pkg.sv
package aud_serial_pkg;

  typedef enum logic [2:0] {
    FMT_I2S = 3'd0,
    FMT_RJ  = 3'd1,
    FMT_DSP = 3'd2,
    FMT_LJ  = 3'd3
  } fmt_e;

  // Codes above 3 fall back to I2S framing.
  function automatic fmt_e decode_fmt(input logic [2:0] code);
    case (code)
      3'd1:    return FMT_RJ;
      3'd2:    return FMT_DSP;
      3'd3:    return FMT_LJ;
      default: return FMT_I2S;
    endcase
  endfunction

  function automatic logic [5:0] word_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return 6'd16;
      2'd1:    return 6'd20;
      default: return 6'd24;
    endcase
  endfunction

endpackage

// File: rtl/aud_bclk_gen.sv
module aud_bclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic bclk,
  output logic fall_evt,
  output logic rise_evt
);
  localparam int CNT_W = $clog2(HALF_DIV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt_q <= '0;
      bclk  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      bclk  <= ~bclk;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // Events flag the cycle whose edge moves bclk.
  assign fall_evt = en & wrap & bclk;
  assign rise_evt = en & wrap & ~bclk;
endmodule

// File: rtl/aud_clk_sync.sv
module aud_clk_sync (
  input  logic clk,
  input  logic rst,
  input  logic bclk_ext,
  input  logic fclk_ext,
  output logic fall_evt,
  output logic rise_evt,
  output logic fclk_sync
);
  logic bclk_meta, bclk_sync, bclk_last, fclk_meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_meta <= 1'b0;
      bclk_sync <= 1'b0;
      bclk_last <= 1'b0;
      fclk_meta <= 1'b0;
      fclk_sync <= 1'b0;
    end else begin
      bclk_meta <= bclk_ext;
      bclk_sync <= bclk_meta;
      bclk_last <= bclk_sync;
      fclk_meta <= fclk_ext;
      fclk_sync <= fclk_meta;
    end
  end

  assign fall_evt = bclk_last & ~bclk_sync;
  assign rise_evt = ~bclk_last & bclk_sync;
endmodule

// File: rtl/aud_slot_engine.sv
module aud_slot_engine
  import aud_serial_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_mode,
  input  logic                fall_evt,
  input  logic                rise_evt,
  input  logic                fclk_sync,
  input  logic [2:0]          fmt_sel,
  input  logic [1:0]          width_sel,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  output logic                sdata,
  output logic                fclk_gen
);
  localparam int FRAME_SLOTS = 2 * SLOT_W;
  localparam int POS_W       = $clog2(FRAME_SLOTS);
  localparam logic [SAMPLE_W-1:0] MSB_ONE = {1'b1, {(SAMPLE_W-1){1'b0}}};

  fmt_e                fmt;
  logic [POS_W-1:0]    pos_q, pos_nxt;
  logic [SAMPLE_W-1:0] left_q, right_q, src_l, src_r, word;
  logic                use_right, hit, bit_nxt, fclk_nxt, fclk_seen, frame_start;
  int                  wlen, slot, half_slot, k;

  assign pos_nxt = pos_q + 1'b1;

  always_comb begin
    fmt       = decode_fmt(fmt_sel);
    wlen      = int'(word_len(width_sel));
    slot      = int'(pos_nxt);
    half_slot = int'(pos_nxt[POS_W-2:0]);
    use_right = pos_nxt[POS_W-1];
    hit       = 1'b0;
    k         = 0;
    case (fmt)
      FMT_I2S: begin
        hit = (half_slot >= 1) && (half_slot <= wlen);
        k   = half_slot - 1;
      end
      FMT_LJ: begin
        hit = (half_slot < wlen);
        k   = half_slot;
      end
      FMT_RJ: begin
        hit = (half_slot >= SLOT_W - wlen);
        k   = half_slot - (SLOT_W - wlen);
      end
      FMT_DSP: begin
        use_right = (slot > wlen);
        hit       = (slot >= 1) && (slot <= 2 * wlen);
        k         = use_right ? slot - 1 - wlen : slot - 1;
      end
      default: ;
    endcase
    if (!hit) k = 0;
    src_l   = (pos_nxt == '0) ? left_in  : left_q;
    src_r   = (pos_nxt == '0) ? right_in : right_q;
    word    = use_right ? src_r : src_l;
    bit_nxt = hit & (|(word & (MSB_ONE >> k)));
    case (fmt)
      FMT_I2S: fclk_nxt = pos_nxt[POS_W-1];
      FMT_DSP: fclk_nxt = (pos_nxt == '0);
      default: fclk_nxt = ~pos_nxt[POS_W-1];
    endcase
  end

  // Slave frame start: fclk reaches its left-channel level (low for I2S).
  assign frame_start = (fclk_sync != fclk_seen) && (fclk_sync == (fmt != FMT_I2S));

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q     <= '1;
      left_q    <= '0;
      right_q   <= '0;
      sdata     <= 1'b0;
      fclk_gen  <= 1'b0;
      fclk_seen <= 1'b0;
    end else begin
      if (fall_evt) begin
        pos_q <= pos_nxt;
        sdata <= bit_nxt;
        if (pos_nxt == '0) begin
          left_q  <= left_in;
          right_q <= right_in;
        end
      end else if (rise_evt && !master_mode && frame_start) begin
        pos_q <= '0;
      end
      if (rise_evt) fclk_seen <= fclk_sync;
      if (!master_mode)  fclk_gen <= 1'b0;
      else if (fall_evt) fclk_gen <= fclk_nxt;
    end
  end
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int HALF_DIV = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                master_mode,
  input  logic [2:0]          fmt_sel,
  input  logic [1:0]          width_sel,
  input  logic [SAMPLE_W-1:0] left_in,
  input  logic [SAMPLE_W-1:0] right_in,
  input  logic                bclk_in,
  input  logic                fclk_in,
  output logic                bclk_out,
  output logic                fclk_out,
  output logic                sdata_out
);
  logic gen_fall, gen_rise, ext_fall, ext_rise, ext_fclk;
  logic fall_evt, rise_evt;

  aud_bclk_gen #(.HALF_DIV(HALF_DIV)) u_gen (
    .clk(clk), .rst(rst), .en(master_mode),
    .bclk(bclk_out), .fall_evt(gen_fall), .rise_evt(gen_rise)
  );

  aud_clk_sync u_sync (
    .clk(clk), .rst(rst), .bclk_ext(bclk_in), .fclk_ext(fclk_in),
    .fall_evt(ext_fall), .rise_evt(ext_rise), .fclk_sync(ext_fclk)
  );

  assign fall_evt = master_mode ? gen_fall : ext_fall;
  assign rise_evt = master_mode ? gen_rise : ext_rise;

  aud_slot_engine #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_engine (
    .clk(clk), .rst(rst), .master_mode(master_mode),
    .fall_evt(fall_evt), .rise_evt(rise_evt), .fclk_sync(ext_fclk),
    .fmt_sel(fmt_sel), .width_sel(width_sel),
    .left_in(left_in), .right_in(right_in),
    .sdata(sdata_out), .fclk_gen(fclk_out)
  );
endmodule

// File: rtl/aud_serial_tx_chk.sv
module aud_serial_tx_chk (
  input logic       clk,
  input logic       rst,
  input logic       master_mode,
  input logic [2:0] fmt_sel,
  input logic       bclk_out,
  input logic       fclk_out,
  input logic       sdata_out
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!sdata_out && !bclk_out && !fclk_out));

  assert_data_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(master_mode) && !$stable(sdata_out)) |-> $fell(bclk_out));

  assert_fclk_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(master_mode) && !$stable(fclk_out)) |-> $fell(bclk_out));

  assert_slave_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!master_mode) |-> (!bclk_out && !fclk_out));

  // I2S (R3) and right-justified (R5): the slot at a frame-clock edge carries no data.
  assert_edge_slot_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(master_mode) && !$stable(fclk_out) &&
     ($past(fmt_sel) == 3'd0 || $past(fmt_sel) == 3'd1)) |-> !sdata_out);

  assert_dsp_pulse_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (master_mode && $past(master_mode) && $past(fmt_sel) == 3'd2 && $rose(fclk_out))
      |-> !sdata_out);
endmodule

bind aud_serial_tx aud_serial_tx_chk u_chk (
  .clk(clk), .rst(rst), .master_mode(master_mode), .fmt_sel(fmt_sel),
  .bclk_out(bclk_out), .fclk_out(fclk_out), .sdata_out(sdata_out)
);

// File: tb/aud_serial_tx_test.sv
`timescale 1ns / 100ps
module aud_serial_tx_test;
  localparam int HALF_DIV = 2;
  localparam int NVEC     = 10;
  // {fmt_sel, width_sel, left, right}
  localparam logic [52:0] VECS [NVEC] = '{
    {3'd0, 2'd2, 24'hA5C3F1, 24'h5A3C0F},
    {3'd0, 2'd0, 24'h8001FF, 24'h7FFE00},
    {3'd3, 2'd2, 24'hC0FFEE, 24'h123456},
    {3'd3, 2'd1, 24'hFFFFF0, 24'h00001F},
    {3'd1, 2'd0, 24'h9ABCDE, 24'h6543FF},
    {3'd1, 2'd1, 24'h800000, 24'h7FFFFF},
    {3'd1, 2'd2, 24'hF0F0F1, 24'h0F0F0E},
    {3'd2, 2'd2, 24'hDEADBE, 24'h35C9A7},
    {3'd2, 2'd0, 24'hFFFFFF, 24'hB4B4FF},
    {3'd5, 2'd3, 24'h13579B, 24'hECA864}
  };

  logic        clk = 1'b0, rst = 1'b1, master_mode = 1'b1;
  logic [2:0]  fmt_sel = 3'd0;
  logic [1:0]  width_sel = 2'd2;
  logic [23:0] left_in = '0, right_in = '0;
  logic        bclk_in = 1'b0, fclk_in = 1'b0;
  logic        bclk_out, fclk_out, sdata_out;
  int          checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  aud_serial_tx #(.SAMPLE_W(24), .SLOT_W(32), .HALF_DIV(HALF_DIV)) uut (
    .clk(clk), .rst(rst), .master_mode(master_mode), .fmt_sel(fmt_sel),
    .width_sel(width_sel), .left_in(left_in), .right_in(right_in),
    .bclk_in(bclk_in), .fclk_in(fclk_in), .bclk_out(bclk_out),
    .fclk_out(fclk_out), .sdata_out(sdata_out)
  );

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit i2s_like(input logic [2:0] f);
    return (f == 3'd0) || (f >= 3'd4);
  endfunction

  function automatic string fmt_tag(input logic [2:0] f);
    if (f == 3'd1) return "R5";
    if (f == 3'd2) return "R6";
    if (f == 3'd3) return "R4";
    return "R3";
  endfunction

  function automatic logic [63:0] exp_data(input logic [2:0] f, input logic [1:0] ws,
                                           input logic [23:0] l, input logic [23:0] r);
    logic [63:0] e;
    int w, ls, rs;
    w = (ws == 2'd0) ? 16 : (ws == 2'd1) ? 20 : 24;
    if (f == 3'd1)      begin ls = 32 - w; rs = 64 - w; end
    else if (f == 3'd2) begin ls = 1;      rs = 1 + w;  end
    else if (f == 3'd3) begin ls = 0;      rs = 32;     end
    else                begin ls = 1;      rs = 33;     end
    e = '0;
    for (int i = 0; i < w; i++) begin
      e[ls + i] = l[23 - i];
      e[rs + i] = r[23 - i];
    end
    return e;
  endfunction

  function automatic logic [63:0] exp_fclk(input logic [2:0] f);
    logic [63:0] e;
    for (int s = 0; s < 64; s++) begin
      if (i2s_like(f))     e[s] = (s >= 32);
      else if (f == 3'd2)  e[s] = (s == 0);
      else                 e[s] = (s < 32);
    end
    return e;
  endfunction

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_rise();
    logic prev;
    prev = bclk_out;
    forever begin
      @(negedge clk);
      if (bclk_out && !prev) return;
      prev = bclk_out;
    end
  endtask

  task automatic capture_master(input logic [2:0] f, output logic [63:0] d,
                                output logic [63:0] fr, input bit change,
                                input logic [23:0] nl, input logic [23:0] nr);
    logic last_fc, fc, lvl;
    int guard;
    lvl = i2s_like(f) ? 1'b0 : 1'b1;
    wait_rise();
    last_fc = fclk_out;
    guard = 0;
    forever begin
      wait_rise();
      fc = fclk_out;
      if (fc != last_fc && fc == lvl) break;
      last_fc = fc;
      guard++;
      if (guard > 300) break;
    end
    d[0] = sdata_out;
    fr[0] = fc;
    for (int s = 1; s < 64; s++) begin
      wait_rise();
      if (change && s == 10) begin
        left_in = nl;
        right_in = nr;
      end
      d[s] = sdata_out;
      fr[s] = fclk_out;
    end
  endtask

  task automatic run_slave(input logic [2:0] f, input logic [1:0] ws,
                           input logic [23:0] l, input logic [23:0] r);
    logic [63:0] d, fpat;
    logic quiet;
    master_mode = 1'b0;
    fmt_sel = f;
    width_sel = ws;
    left_in = l;
    right_in = r;
    do_reset();
    fpat = exp_fclk(f);
    quiet = 1'b1;
    d = '0;
    for (int fr = 0; fr < 3; fr++) begin
      for (int s = 0; s < 64; s++) begin
        bclk_in = 1'b0;
        fclk_in = fpat[s];
        repeat (8) @(negedge clk);
        if (fr == 2) d[s] = sdata_out;
        if (bclk_out || fclk_out) quiet = 1'b0;
        bclk_in = 1'b1;
        repeat (8) @(negedge clk);
      end
    end
    check64({"R9 slave data ", fmt_tag(f)}, d, exp_data(f, ws, l, r));
    check64("R9 slave clocks held low", {63'd0, quiet}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] d, fr;
    int n;

    // R1: outputs during and right after reset
    repeat (2) @(negedge clk);
    check64("R1 outputs in reset", {61'd0, sdata_out, bclk_out, fclk_out}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check64("R1 outputs after release", {61'd0, sdata_out, bclk_out, fclk_out}, 64'd0);

    // R2: bit clock period
    wait_rise();
    n = 0;
    begin
      logic p;
      p = bclk_out;
      forever begin
        @(negedge clk);
        n++;
        if (bclk_out && !p) break;
        p = bclk_out;
      end
    end
    check64("R2 bclk period", 64'(n), 64'(2 * HALF_DIV));

    // Table: master mode framing, widths and unused slots (R3 R4 R5 R6 R7 R8)
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0]  f;
      logic [1:0]  ws;
      logic [23:0] l, r;
      {f, ws, l, r} = VECS[v];
      master_mode = 1'b1;
      fmt_sel = f;
      width_sel = ws;
      left_in = l;
      right_in = r;
      do_reset();
      capture_master(f, d, fr, 1'b0, '0, '0);
      capture_master(f, d, fr, 1'b0, '0, '0);
      check64({"data ", fmt_tag(f), " R7 R8"}, d, exp_data(f, ws, l, r));
      check64({"frame clock ", fmt_tag(f), " R2"}, fr, exp_fclk(f));
    end

    // R10: a mid-frame change waits for the next frame
    master_mode = 1'b1;
    fmt_sel = 3'd3;
    width_sel = 2'd2;
    left_in = 24'h3C3C3C;
    right_in = 24'hC3C3C3;
    do_reset();
    capture_master(3'd3, d, fr, 1'b0, '0, '0);
    capture_master(3'd3, d, fr, 1'b1, 24'h0FF0AA, 24'hF00F55);
    check64("R10 current frame keeps old samples", d,
            exp_data(3'd3, 2'd2, 24'h3C3C3C, 24'hC3C3C3));
    capture_master(3'd3, d, fr, 1'b0, '0, '0);
    check64("R10 next frame uses new samples", d,
            exp_data(3'd3, 2'd2, 24'h0FF0AA, 24'hF00F55));

    // R9: slave mode with external clocks
    run_slave(3'd0, 2'd1, 24'hA1B2C3, 24'h5D6E7F);
    run_slave(3'd3, 2'd2, 24'h87654F, 24'h1ABCDE);
    run_slave(3'd2, 2'd0, 24'hC0C0C0, 24'h3F3F3F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule